// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver with Eight-Deep Queues

This block is a full-duplex asynchronous serial port. It has a transmit path and a receive path, and each path has its own eight-entry character queue. Both paths time their bits from a clock-enable pulse, `tick`, that arrives sixteen times per bit period. A baud divider outside the block produces that pulse. Software sets the frame shape through static configuration inputs: 7 or 8 data bits, a parity policy and one or two stop bits. Characters are moved through a write strobe on the transmit side and a show-ahead read port on the receive side.

The receiver synchronises its serial input and decides each bit by a two-of-three vote. It rejects start pulses that are too short, and it flags parity, framing, overrun and break conditions. The transmitter can hold the line low to send a break. A loopback switch feeds the outgoing serial stream into the receiver inside the block and keeps the external line idle. Eight status sources are visible at once, and each one has a mask bit. The masked sources are OR-ed into a single interrupt output.

Top module: `uart_core`

## Requirements
- R1: After reset, `txd` is 1, both queues are empty, `tx_full` is 0 and `irq_stat` equals 8'h0C (transmit queue empty and transmitter idle).
- R2: A received frame is a low start bit, then the data bits least significant first, then optional parity, then stop. Each bit lasts 16 ticks. With 8 data bits and no parity, the byte appears on `rx_data` with `rx_empty` low.
- R3: `cfg_par` encodes 00 none, 01 even, 10 odd, 11 forced-error. The receiver checks the parity bit against even parity in modes 01 and 11, and against odd parity in mode 10. A mismatch sets `irq_stat[4]`, and the character is still stored. In 7-bit mode (`cfg_len8`=0) the stored character has bit 7 equal to 0.
- R4: Each received bit is the majority of the samples taken at ticks 7, 8 and 9 of the bit. A start bit that votes high at mid-bit is dropped, so a short low glitch stores nothing and sets no error.
- R5: A stop bit that votes low in a frame with at least one 1 bit sets `irq_stat[5]`, and the character is stored.
- R6: A frame that is all zero, stop bit included, sets `irq_stat[7]` (break). It stores no character and does not set `irq_stat[5]`. The receiver then waits for a high line before it looks for the next start bit.
- R7: A character that completes while the receive queue holds 8 entries is discarded and sets `irq_stat[6]`. The 8 queued characters are kept in order.
- R8: The transmitter sends the frame that R2 and R3 describe, with two high stop bits when `cfg_stop2`=1. In mode 11 the parity bit it sends is the inverse of even parity.
- R9: The transmit queue holds 8 characters beside the one being shifted out. `tx_full` is 1 when the queue holds 8, and a write while full is ignored.
- R10: While `cfg_brk`=1 and `cfg_loop`=0, `txd` is 0.
- R11: With `cfg_loop`=1, the receiver takes its input from the transmit stream (after the break override) and `txd` stays 1.
- R12: `irq_stat` bits 0..3 are levels: receive queue not empty, receive queue full, transmit queue empty, transmit queue empty with the transmitter idle. Bits 4..7 are sticky. A 1 in `irq_clr` clears a sticky bit unless a new event arrives in the same cycle. `irq` is the OR of `irq_stat & irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable at 16 times the bit rate |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par | input | 2 | Parity policy (R3) |
| cfg_stop2 | input | 1 | 1: transmit two stop bits |
| cfg_loop | input | 1 | Internal loopback |
| cfg_brk | input | 1 | Drive a break on the line |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_data | input | 8 | Character to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| irq_mask | input | 8 | Mask for each status source |
| irq_clr | input | 8 | Write-1 clear for sticky status bits |
| irq_stat | output | 8 | Status sources (R12) |
| irq | output | 1 | Masked interrupt request |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The embedded assertions check five properties on every cycle. A queue never holds more than its depth. A dequeue always starts a transmitter frame. A break never stores a character and is never also reported as a framing error. An overrun happens only against a full queue. A parity event is always latched into the status the next cycle. The bench's scenarios are the only place where the bit order, frame lengths, majority voting, glitch rejection, ordering through a full queue and the loopback path can be seen. There a behavioural line decoder and frame driver stand in for the far end. The bench also keeps a per-cycle model of the break and loopback line level and of the masked interrupt, and compares it every cycle.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_FORCE = 2'b11
  } par_e;

  localparam int unsigned IRQ_N     = 8;
  localparam int unsigned BIT_TICKS = 16;

  // parity over the active data bits; odd=1 inverts the even result
  function automatic logic par_calc(logic [7:0] d, logic len8, logic odd);
    logic e;
    e = ^{d[7] & len8, d[6:0]};
    return e ^ odd;
  endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    cnt_n = cnt_q;
    if (do_push && !do_pop) cnt_n = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_n;
    end
  end

  a_r9_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       len8,
  input  par_e       par,
  input  logic       stop2,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       q_pop,
  output logic       line,
  output logic       idle
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_e;
  localparam logic [3:0] LAST_TICK = 4'(BIT_TICKS - 1);

  tst_e       st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic [2:0] bit_q, bit_n;
  logic       pb_q, pb_n, line_q, line_n, last;

  assign last = tick && (cnt_q == LAST_TICK);
  assign line = line_q;
  assign idle = (st_q == T_IDLE);

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; bit_n = bit_q; pb_n = pb_q;
    q_pop = 1'b0; line_n = 1'b1;
    if (st_q != T_IDLE && tick) cnt_n = cnt_q + 4'd1;
    case (st_q)
      T_IDLE: if (!q_empty) begin
        q_pop = 1'b1;
        sh_n  = q_data;
        pb_n  = par_calc(q_data, len8, (par == PAR_ODD) || (par == PAR_FORCE));
        st_n  = T_START;
        cnt_n = '0;
        bit_n = '0;
      end
      T_START: begin
        line_n = 1'b0;
        if (last) st_n = T_DATA;
      end
      T_DATA: begin
        line_n = sh_q[0];
        if (last) begin
          sh_n  = {1'b0, sh_q[7:1]};
          bit_n = bit_q + 3'd1;
          if (bit_q == (len8 ? 3'd7 : 3'd6)) begin
            bit_n = '0;
            st_n  = (par == PAR_NONE) ? T_STOP : T_PAR;
          end
        end
      end
      T_PAR: begin
        line_n = pb_q;
        if (last) st_n = T_STOP;
      end
      T_STOP: if (last) begin
        if (stop2 && bit_q == 3'd0) bit_n = 3'd1;
        else st_n = T_IDLE;
      end
      default: st_n = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= T_IDLE; cnt_q <= '0; sh_q <= '0; bit_q <= '0;
      pb_q <= 1'b0; line_q <= 1'b1;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; bit_q <= bit_n;
      pb_q <= pb_n; line_q <= line_n;
    end
  end

  a_r8_pop_starts: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> !idle);
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       len8,
  input  par_e       par,
  input  logic       q_full,
  output logic       push,
  output logic [7:0] dat,
  output logic       perr,
  output logic       ferr,
  output logic       oerr,
  output logic       brk
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAIT} rst_e;
  localparam logic [3:0] LAST_TICK = 4'(BIT_TICKS - 1);

  rst_e       st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic [2:0] bit_q, bit_n;
  logic [1:0] smp_q, smp_n;
  logic       s1_q, s2_q, pr_q, pr_n, any_q, any_n, vote, mid, last, fin;

  assign vote = (smp_q[0] & smp_q[1]) | (smp_q[0] & s2_q) | (smp_q[1] & s2_q);
  assign mid  = tick && (cnt_q == 4'd9);
  assign last = tick && (cnt_q == LAST_TICK);
  assign dat  = len8 ? sh_q : {1'b0, sh_q[7:1]};
  assign fin  = (st_q == R_STOP) && mid;
  assign brk  = fin && !any_q && !vote;
  assign push = fin && !brk && !q_full;
  assign oerr = fin && !brk && q_full;
  assign ferr = fin && !brk && !vote;
  assign perr = fin && !brk && (par != PAR_NONE) &&
                (pr_q != par_calc(dat, len8, par == PAR_ODD));

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; bit_n = bit_q;
    smp_n = smp_q; pr_n = pr_q; any_n = any_q;
    if (st_q != R_IDLE && st_q != R_WAIT && tick) begin
      cnt_n = cnt_q + 4'd1;
      if (cnt_q == 4'd7) smp_n[0] = s2_q;
      if (cnt_q == 4'd8) smp_n[1] = s2_q;
    end
    case (st_q)
      R_IDLE: if (tick && !s2_q) begin
        st_n = R_START; cnt_n = '0; any_n = 1'b0; bit_n = '0;
      end
      R_START: begin
        if (mid && vote) st_n = R_IDLE;
        else if (last) st_n = R_DATA;
      end
      R_DATA: begin
        if (mid) begin
          sh_n  = {vote, sh_q[7:1]};
          any_n = any_q | vote;
        end
        if (last) begin
          bit_n = bit_q + 3'd1;
          if (bit_q == (len8 ? 3'd7 : 3'd6))
            st_n = (par == PAR_NONE) ? R_STOP : R_PAR;
        end
      end
      R_PAR: begin
        if (mid) begin
          pr_n  = vote;
          any_n = any_q | vote;
        end
        if (last) st_n = R_STOP;
      end
      R_STOP: if (mid) st_n = vote ? R_IDLE : R_WAIT;
      R_WAIT: if (s2_q) st_n = R_IDLE;
      default: st_n = R_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1; st_q <= R_IDLE; cnt_q <= '0; sh_q <= '0;
      bit_q <= '0; smp_q <= 2'b11; pr_q <= 1'b0; any_q <= 1'b0;
    end else begin
      s1_q <= rx_in; s2_q <= s1_q; st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n;
      bit_q <= bit_n; smp_q <= smp_n; pr_q <= pr_n; any_q <= any_n;
    end
  end

  a_r6_break_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !push && !ferr);
  a_r7_overrun_drop: assert property (@(posedge clk) disable iff (!rst_n)
    oerr |-> q_full && !push);
endmodule

// File: rtl/uart_core.sv
module uart_core import uart_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_len8,
  input  logic [1:0] cfg_par,
  input  logic       cfg_stop2,
  input  logic       cfg_loop,
  input  logic       cfg_brk,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_full,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_empty,
  input  logic [7:0] irq_mask,
  input  logic [7:0] irq_clr,
  output logic [7:0] irq_stat,
  output logic       irq,
  input  logic       rxd,
  output logic       txd
);
  localparam int unsigned STK_N = IRQ_N / 2;

  par_e       pmode;
  logic       txq_empty, tx_pop, tx_line, tx_idle, ser_line, rx_in;
  logic [7:0] txq_data, rx_char;
  logic       rx_push, rx_full, ev_perr, ev_ferr, ev_oerr, ev_brk;
  logic [STK_N-1:0] stk_q, stk_n, ev;

  assign pmode = par_e'(cfg_par);

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(tx_data), .pop(tx_pop),
    .dout(txq_data), .empty(txq_empty), .full(tx_full));

  uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len8(cfg_len8), .par(pmode),
    .stop2(cfg_stop2), .q_empty(txq_empty), .q_data(txq_data), .q_pop(tx_pop),
    .line(tx_line), .idle(tx_idle));

  assign ser_line = cfg_brk ? 1'b0 : tx_line;
  assign txd      = cfg_loop ? 1'b1 : ser_line;
  assign rx_in    = cfg_loop ? ser_line : rxd;

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in), .len8(cfg_len8),
    .par(pmode), .q_full(rx_full), .push(rx_push), .dat(rx_char),
    .perr(ev_perr), .ferr(ev_ferr), .oerr(ev_oerr), .brk(ev_brk));

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_char), .pop(rx_rd),
    .dout(rx_data), .empty(rx_empty), .full(rx_full));

  assign ev    = {ev_brk, ev_oerr, ev_ferr, ev_perr};
  assign stk_n = (stk_q & ~irq_clr[IRQ_N-1:STK_N]) | ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stk_q <= '0;
    else        stk_q <= stk_n;
  end

  assign irq_stat = {stk_q, txq_empty & tx_idle, txq_empty, rx_full, !rx_empty};
  assign irq      = |(irq_stat & irq_mask);

  a_r12_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_perr |=> irq_stat[4]);
endmodule

// File: tb/tb_uart_core.sv
module tb_uart_core;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cfg_len8 = 1'b1, cfg_stop2 = 1'b0, cfg_loop = 1'b0, cfg_brk = 1'b0;
  logic [1:0] cfg_par = 2'b00;
  logic tx_wr = 1'b0, rx_rd = 1'b0, rxd = 1'b1;
  logic [7:0] tx_data = '0, irq_mask = '0, irq_clr = '0;
  logic tx_full, rx_empty, irq, txd;
  logic [7:0] rx_data, irq_stat;

  int checks = 0, errors = 0, tdiv = 0;
  bit dec_en = 1'b0, done = 1'b0;
  logic [7:0] dq_d[$];
  bit dq_p[$], dq_s[$];

  uart_core dut (.clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len8(cfg_len8),
    .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .cfg_loop(cfg_loop), .cfg_brk(cfg_brk),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_empty(rx_empty), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .irq_stat(irq_stat), .irq(irq), .rxd(rxd), .txd(txd));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // per-cycle reference: line level under break/loopback, masked interrupt
  always @(negedge clk) if (rst_n && !done) begin
    chk("R12 irq", irq, |(irq_stat & irq_mask));
    if (cfg_loop) chk("R11 txd idle in loopback", txd, 1'b1);
    else if (cfg_brk) chk("R10 break low", txd, 1'b0);
  end

  // behavioural far-end decoder of txd
  initial forever begin
    @(negedge clk);
    if (dec_en && txd === 1'b0) begin
      logic [7:0] d;
      bit p, s;
      d = '0; p = 1'b0;
      repeat (32) @(negedge clk);
      if (txd === 1'b0) begin
        for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) begin
          repeat (64) @(negedge clk);
          d[i] = txd;
        end
        if (cfg_par != 2'b00) begin
          repeat (64) @(negedge clk);
          p = txd;
        end
        repeat (64) @(negedge clk);
        s = txd;
        if (cfg_stop2) begin
          repeat (64) @(negedge clk);
          s = s & txd;
        end
        dq_d.push_back(d); dq_p.push_back(p); dq_s.push_back(s);
      end
    end
  end

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit l8, input bit pon,
                             input bit podd, input bit pbad, input bit stopv);
    bit e;
    e = 1'b0;
    send_bit(1'b0);
    for (int i = 0; i < (l8 ? 8 : 7); i++) begin
      send_bit(d[i]);
      e ^= d[i];
    end
    if (pon) send_bit(e ^ podd ^ pbad);
    send_bit(stopv);
    rxd = 1'b1;
    repeat (96) @(negedge clk);
  endtask

  task automatic rd(input string rq, input logic [7:0] exp);
    chk(rq, rx_empty, 1'b0);
    chk(rq, rx_data, exp);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic clr_all();
    irq_clr = 8'hF0;
    @(negedge clk);
    irq_clr = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    tx_wr = 1'b1; tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_tx_done();
    repeat (5) @(negedge clk);
    while (irq_stat[3] !== 1'b1) @(negedge clk);
    repeat (80) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1'b1);
    chk("R1 rx_empty", rx_empty, 1'b1);
    chk("R1 tx_full", tx_full, 1'b0);
    chk("R1 irq_stat", irq_stat, 8'h0C);

    // R2 8N1 receive
    drive_frame(8'hA5, 1, 0, 0, 0, 1);
    rd("R2 8N1 data", 8'hA5);
    chk("R2 no errors", irq_stat[7:4], 4'h0);

    // R3 7-bit even parity, good
    cfg_len8 = 1'b0; cfg_par = 2'b01;
    drive_frame(8'h35, 0, 1, 0, 0, 1);
    rd("R3 7E1 data", 8'h35);
    chk("R3 no parity error", irq_stat[4], 1'b0);

    // R3 odd parity with a bad bit
    cfg_par = 2'b10;
    drive_frame(8'h0F, 0, 1, 1, 1, 1);
    rd("R3 bad parity char kept", 8'h0F);
    chk("R3 parity error", irq_stat[4], 1'b1);
    clr_all();
    chk("R12 sticky cleared", irq_stat[4], 1'b0);

    // R5 framing error
    cfg_len8 = 1'b1; cfg_par = 2'b00;
    drive_frame(8'h3C, 1, 0, 0, 0, 0);
    chk("R5 framing error", irq_stat[5], 1'b1);
    chk("R5 not break", irq_stat[7], 1'b0);
    rd("R5 char kept", 8'h3C);
    clr_all();

    // R6 break
    drive_frame(8'h00, 1, 0, 0, 0, 0);
    chk("R6 break flag", irq_stat[7], 1'b1);
    chk("R6 no framing flag", irq_stat[5], 1'b0);
    chk("R6 nothing stored", rx_empty, 1'b1);
    drive_frame(8'h81, 1, 0, 0, 0, 1);
    rd("R6 recovery after break", 8'h81);
    clr_all();

    // R4 short glitch rejected
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk("R4 glitch stores nothing", rx_empty, 1'b1);
    chk("R4 glitch no flags", irq_stat[7:4], 4'h0);

    // R7 overrun
    for (int i = 0; i < 9; i++) drive_frame(8'(8'h10 + i), 1, 0, 0, 0, 1);
    chk("R7 overrun flag", irq_stat[6], 1'b1);
    chk("R12 rx full level", irq_stat[1], 1'b1);
    for (int i = 0; i < 8; i++) rd("R7 kept order", 8'(8'h10 + i));
    chk("R7 ninth dropped", rx_empty, 1'b1);
    clr_all();

    // R8 transmit formats
    dec_en = 1'b1;
    wr(8'h5A);
    wait_tx_done();
    chk("R8 8N1 count", dq_d.size(), 1);
    chk("R8 8N1 data", dq_d.pop_front(), 8'h5A);
    chk("R8 8N1 stop", dq_s.pop_front(), 1'b1);
    void'(dq_p.pop_front());

    cfg_len8 = 1'b0; cfg_par = 2'b10; cfg_stop2 = 1'b1;
    wr(8'h13);
    wait_tx_done();
    chk("R8 7O2 data", dq_d.pop_front(), 8'h13);
    chk("R8 7O2 parity", dq_p.pop_front(), 1'b0);
    chk("R8 7O2 two stops", dq_s.pop_front(), 1'b1);

    cfg_len8 = 1'b1; cfg_par = 2'b11; cfg_stop2 = 1'b0;
    wr(8'h5A);
    wait_tx_done();
    chk("R8 forced data", dq_d.pop_front(), 8'h5A);
    chk("R8 forced parity inverted", dq_p.pop_front(), 1'b1);
    void'(dq_s.pop_front());

    // R9 transmit queue full
    cfg_par = 2'b00;
    for (int i = 0; i < 9; i++) wr(8'(8'h60 + i));
    chk("R9 tx_full", tx_full, 1'b1);
    wr(8'hEE);
    wait_tx_done();
    chk("R9 frame count", dq_d.size(), 9);
    for (int i = 0; i < 9; i++) chk("R9 order", dq_d.pop_front(), 8'(8'h60 + i));
    dq_p.delete(); dq_s.delete();
    dec_en = 1'b0;

    // R10 break generation
    cfg_brk = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 txd low", txd, 1'b0);
    cfg_brk = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 txd released", txd, 1'b1);
    clr_all();

    // R11 loopback
    cfg_loop = 1'b1; cfg_par = 2'b01;
    repeat (100) @(negedge clk);
    wr(8'hC3);
    wait_tx_done();
    rd("R11 loopback data", 8'hC3);
    chk("R11 no parity error", irq_stat[4], 1'b0);

    // R8/R3 forced mode seen by own receiver
    cfg_par = 2'b11;
    wr(8'h5A);
    wait_tx_done();
    rd("R8 forced char looped", 8'h5A);
    chk("R3 forced parity flagged", irq_stat[4], 1'b1);

    // R12 masking
    irq_mask = 8'h00;
    @(negedge clk);
    chk("R12 masked", irq, 1'b0);
    irq_mask = 8'h10;
    @(negedge clk);
    chk("R12 unmasked", irq, 1'b1);
    clr_all();
    chk("R12 cleared irq", irq, 1'b0);
    cfg_loop = 1'b0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule